// File: doc/BRIEF.md
# Two-wire serial memory slave with write-cycle busy

This block is the slave side of a two-wire (I2C-style) serial bus in front of a small register array. It brings SCL and SDA into the system clock, detects START, repeated START and STOP, and decodes a transfer. A transfer begins with an address byte that carries a read/write flag, then a two-byte word address, then data. The block supports single-byte writes, reads at the current address, random reads and sequential reads. The only output is an open-drain pull-down enable for SDA.

A write goes into the array only when STOP arrives on a byte boundary after a data byte and its acknowledge clock. The block then runs a modelled programming cycle of a fixed number of system clocks. During that cycle it does not acknowledge its own address, so a host can poll with repeated START plus address until it gets an ACK. An internal word counter points one past the last word written or read. Current-address and sequential reads run from that counter.

Top module: `eep_slave`

## Requirements
- R1: After reset the block releases SDA (`sdaOe` = 0) and waits for a START.
- R2: The first byte after a START or repeated START is taken MSB first. Bits 7..1 are compared with `DEV_ADDR`, and bit 0 is the direction (1 = read, 0 = write). On a match the block pulls SDA low during the ninth clock. On a mismatch it leaves SDA released and ignores all clocks until the next START or STOP.
- R3: In a write transfer the two bytes after the address byte are the word address, high byte first. Only the low log2(`DEPTH`) bits of the 16-bit value are used, and the upper bits have no effect. Every received byte is acknowledged.
- R4: A STOP that follows the ACK clock of a data byte directly stores the most recently received data byte at the word address. After that the word counter holds that address plus one. When several data bytes were sent, only the last one is stored.
- R5: A STOP inside a data byte, or before the first data byte's ACK clock, leaves the array unchanged and starts no write cycle.
- R6: After a stored write the block is busy for `WR_CYCLES` system clocks. While busy, an address byte of either direction gets no ACK. Once the cycle ends, the same address byte is acknowledged.
- R7: A read transfer without a word address returns the byte at the word counter. Every byte read advances the counter by one, modulo `DEPTH` (a power of two).
- R8: A write-direction address byte and a word address, followed by a repeated START and a read-direction address byte, returns the byte at that word address.
- R9: Read data is sent MSB first. If the host pulls SDA low in the ninth clock, the next byte follows. If the host leaves SDA high, the block releases SDA until the next START or STOP.
- R10: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaOe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
On every cycle the assertions check three things. The address is never acknowledged while the write cycle runs. A STOP before the first data ACK or inside a byte never starts a write cycle, and a write cycle begins only from a commit strobe. The SDA drive holds steady while SCL is high. Only the bench scenarios can show the data-level behaviour. That covers the value stored by a multi-byte write, the upper word-address bits having no effect, the counter wrap in current-address and sequential reads, and the length of the busy window as seen by acknowledge polling.

// File: rtl/eep_pkg.sv
`timescale 1ns/1ps
package eep_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DEVADR,
    S_ACKDEV,
    S_WADDRH,
    S_ACKAH,
    S_WADDRL,
    S_ACKAL,
    S_WDATA,
    S_ACKDAT,
    S_RDATA,
    S_RACK,
    S_IGNORE
  } busState_t;

  typedef struct packed {
    logic shiftIn;
    logic loadHi;
    logic loadLo;
    logic latchData;
    logic commit;
    logic loadRd;
    logic shiftOut;
  } dpCtl_t;

endpackage

// File: rtl/eep_busmon.sv
`timescale 1ns/1ps
module eep_busmon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet,
  output logic sdaS,
  output logic sclHigh
);

  logic [SYNC_STAGES-1:0] sclQ;
  logic [SYNC_STAGES-1:0] sdaQ;
  logic sclD;
  logic sdaD;
  logic sclS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= '1;
      sdaQ <= '1;
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclQ <= {sclQ[SYNC_STAGES-2:0], sclIn};
      sdaQ <= {sdaQ[SYNC_STAGES-2:0], sdaIn};
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  assign sclS     = sclQ[SYNC_STAGES-1];
  assign sdaS     = sdaQ[SYNC_STAGES-1];
  assign sclHigh  = sclS;
  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;

endmodule

// File: rtl/eep_dp.sv
`timescale 1ns/1ps
module eep_dp
  import eep_pkg::*;
#(
  parameter int DEPTH     = 512,
  parameter int WR_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCtl_t     ctl,
  input  logic       sdaS,
  output logic [7:0] rxByte,
  output logic       txBit,
  output logic       busy
);

  localparam int AW = $clog2(DEPTH);
  localparam int TW = $clog2(WR_CYCLES + 1);

  logic [7:0]    shIn;
  logic [7:0]    shOut;
  logic [7:0]    hiTmp;
  logic [7:0]    wrBuf;
  logic [AW-1:0] addrCnt;
  logic [TW-1:0] tmr;
  logic [7:0]    mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shIn    <= '0;
      shOut   <= '0;
      hiTmp   <= '0;
      wrBuf   <= '0;
      addrCnt <= '0;
      tmr     <= '0;
    end else begin
      if (ctl.shiftIn)   shIn  <= {shIn[6:0], sdaS};
      if (ctl.loadHi)    hiTmp <= shIn;
      if (ctl.latchData) wrBuf <= shIn;
      if (ctl.loadLo)    addrCnt <= AW'({hiTmp, shIn});
      if (ctl.loadRd) begin
        shOut   <= mem[addrCnt];
        addrCnt <= addrCnt + 1'b1;
      end else if (ctl.shiftOut) begin
        shOut <= {shOut[6:0], 1'b0};
      end
      if (ctl.commit) begin
        addrCnt <= addrCnt + 1'b1;
        tmr     <= TW'(WR_CYCLES);
      end else if (tmr != '0) begin
        tmr <= tmr - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.commit) mem[addrCnt] <= wrBuf;
  end

  assign rxByte = shIn;
  assign txBit  = shOut[7];
  assign busy   = (tmr != '0);

  AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(ctl.commit)); // R6

endmodule

// File: rtl/eep_ctrl.sv
`timescale 1ns/1ps
module eep_ctrl
  import eep_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       sdaS,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  input  logic       busy,
  output dpCtl_t     ctl,
  output logic       sdaOe
);

  busState_t st, stNxt;
  logic [3:0] bitCnt, cntNxt;
  logic       rwBit, rwNxt;
  logic       pending, pendNxt;
  logic       mAck, mAckNxt;
  logic       addrHit;

  assign addrHit = (rxByte[7:1] == DEV_ADDR) && !busy;

  always_comb begin
    stNxt   = st;
    cntNxt  = bitCnt;
    rwNxt   = rwBit;
    pendNxt = pending;
    mAckNxt = mAck;
    ctl     = '0;
    if (stopDet) begin
      // the STOP's own SCL rise is the only clock after the byte boundary
      if (st == S_WDATA && pending && bitCnt <= 4'd1) ctl.commit = 1'b1;
      stNxt   = S_IDLE;
      cntNxt  = '0;
      pendNxt = 1'b0;
    end else if (startDet) begin
      stNxt   = S_DEVADR;
      cntNxt  = '0;
      pendNxt = 1'b0;
    end else begin
      case (st)
        S_DEVADR, S_WADDRH, S_WADDRL, S_WDATA: begin
          if (sclRise) begin
            ctl.shiftIn = 1'b1;
            cntNxt      = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            cntNxt = '0;
            case (st)
              S_DEVADR: begin
                if (addrHit) begin
                  rwNxt = rxByte[0];
                  stNxt = S_ACKDEV;
                end else begin
                  stNxt = S_IGNORE;
                end
              end
              S_WADDRH: begin
                ctl.loadHi = 1'b1;
                stNxt      = S_ACKAH;
              end
              S_WADDRL: begin
                ctl.loadLo = 1'b1;
                stNxt      = S_ACKAL;
              end
              default: begin
                ctl.latchData = 1'b1;
                stNxt         = S_ACKDAT;
              end
            endcase
          end
        end
        S_ACKDEV, S_ACKAH, S_ACKAL, S_ACKDAT: begin
          if (sclRise) begin
            cntNxt = 4'd1;
          end else if (sclFall && bitCnt == 4'd1) begin
            cntNxt = '0;
            case (st)
              S_ACKDEV: begin
                if (rwBit) begin
                  ctl.loadRd = 1'b1;
                  stNxt      = S_RDATA;
                end else begin
                  stNxt = S_WADDRH;
                end
              end
              S_ACKAH: stNxt = S_WADDRL;
              S_ACKAL: stNxt = S_WDATA;
              default: begin
                stNxt   = S_WDATA;
                pendNxt = 1'b1;
              end
            endcase
          end
        end
        S_RDATA: begin
          if (sclRise) begin
            cntNxt = bitCnt + 4'd1;
          end else if (sclFall) begin
            if (bitCnt == 4'd8) begin
              cntNxt = '0;
              stNxt  = S_RACK;
            end else begin
              ctl.shiftOut = 1'b1;
            end
          end
        end
        S_RACK: begin
          if (sclRise) begin
            mAckNxt = ~sdaS;
            cntNxt  = 4'd1;
          end else if (sclFall && bitCnt == 4'd1) begin
            cntNxt = '0;
            if (mAck) begin
              ctl.loadRd = 1'b1;
              stNxt      = S_RDATA;
            end else begin
              stNxt = S_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= S_IDLE;
      bitCnt  <= '0;
      rwBit   <= 1'b0;
      pending <= 1'b0;
      mAck    <= 1'b0;
    end else begin
      st      <= stNxt;
      bitCnt  <= cntNxt;
      rwBit   <= rwNxt;
      pending <= pendNxt;
      mAck    <= mAckNxt;
    end
  end

  always_comb begin
    case (st)
      S_ACKDEV, S_ACKAH, S_ACKAL, S_ACKDAT: sdaOe = 1'b1;
      S_RDATA:                              sdaOe = ~txBit;
      default:                              sdaOe = 1'b0;
    endcase
  end

  AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    st == S_ACKDEV |-> !busy); // R6

  AST_EARLY_STOP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    stopDet && (st == S_WADDRH || st == S_WADDRL ||
                (st == S_WDATA && (!pending || bitCnt > 4'd1))) |=> !busy); // R5

endmodule

// File: rtl/eep_slave.sv
`timescale 1ns/1ps
module eep_slave
  import eep_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter int         DEPTH     = 512,
  parameter int         WR_CYCLES = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe
);

  logic       sclRise;
  logic       sclFall;
  logic       startDet;
  logic       stopDet;
  logic       sdaS;
  logic       sclHigh;
  logic [7:0] rxByte;
  logic       txBit;
  logic       busy;
  dpCtl_t     ctl;

  eep_busmon #(.SYNC_STAGES(2)) u_busmon (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet),
    .sdaS     (sdaS),
    .sclHigh  (sclHigh)
  );

  eep_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet),
    .sdaS     (sdaS),
    .rxByte   (rxByte),
    .txBit    (txBit),
    .busy     (busy),
    .ctl      (ctl),
    .sdaOe    (sdaOe)
  );

  eep_dp #(.DEPTH(DEPTH), .WR_CYCLES(WR_CYCLES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .sdaS   (sdaS),
    .rxByte (rxByte),
    .txBit  (txBit),
    .busy   (busy)
  );

  AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    sclHigh && $past(sclHigh) |-> $stable(sdaOe)); // R10

endmodule

// File: tb/sim_eep_slave.sv
`timescale 1ns/1ps
module sim_eep_slave;

  localparam int         Q     = 10;
  localparam int         DEPTH = 512;
  localparam logic [6:0] DEV   = 7'h50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mstLow = 1'b0;
  logic sdaOe;
  logic sdaLine;

  always #2.5 clk = ~clk;

  assign sdaLine = ~(mstLow | sdaOe);

  eep_slave #(.DEV_ADDR(DEV), .DEPTH(DEPTH), .WR_CYCLES(1000)) u0 (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (scl),
    .sdaIn (sdaLine),
    .sdaOe (sdaOe)
  );

  int total = 0;
  int bad = 0;
  int sclHighFlips = 0;
  logic [7:0] model [DEPTH];
  bit known [DEPTH];
  int modelAddr = 0;
  int wl [16];
  int wlCnt = 0;
  logic prevScl = 1'b1;
  logic prevOe = 1'b0;

  // R10 monitor: drive must not move while SCL stays high
  always @(negedge clk) begin
    if (rstN && scl && prevScl && (sdaOe !== prevOe)) sclHighFlips++;
    prevScl <= scl;
    prevOe  <= sdaOe;
  end

  function automatic int effAddr(int hi, int lo);
    return ((hi << 8) | lo) % DEPTH;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    mstLow = 1'b0; hold(Q);
    scl = 1'b1;    hold(Q);
    mstLow = 1'b1; hold(Q);
    scl = 1'b0;    hold(Q);
  endtask

  task automatic busStop();
    mstLow = 1'b1; hold(Q);
    scl = 1'b1;    hold(Q);
    mstLow = 1'b0; hold(Q);
  endtask

  task automatic putBits(logic [7:0] b, int n);
    for (int i = 0; i < n; i++) begin
      mstLow = ~b[7-i]; hold(Q);
      scl = 1'b1;       hold(2*Q);
      scl = 1'b0;       hold(Q);
    end
  endtask

  task automatic sendByte(logic [7:0] b, output bit ack);
    putBits(b, 8);
    mstLow = 1'b0; hold(Q);
    scl = 1'b1;    hold(Q);
    ack = ~sdaLine; hold(Q);
    scl = 1'b0;    hold(Q);
  endtask

  task automatic recvByte(bit hostAck, output logic [7:0] b);
    mstLow = 1'b0;
    for (int i = 0; i < 8; i++) begin
      hold(Q);
      scl = 1'b1; hold(Q);
      b[7-i] = sdaLine; hold(Q);
      scl = 1'b0;
    end
    hold(2);
    mstLow = hostAck; hold(Q);
    scl = 1'b1; hold(2*Q);
    scl = 1'b0; hold(Q);
    mstLow = 1'b0;
  endtask

  task automatic pollReady(output int tries);
    bit a;
    tries = 0;
    do begin
      busStart();
      sendByte({DEV, 1'b0}, a);
      busStop();
      tries++;
    end while (!a && tries < 20);
  endtask

  task automatic writeHdr(int hi, int lo);
    bit a;
    busStart();
    sendByte({DEV, 1'b0}, a); check(a, "R2 write address ack", a, 1);
    sendByte(hi[7:0], a);     check(a, "R3 high word byte ack", a, 1);
    sendByte(lo[7:0], a);     check(a, "R3 low word byte ack", a, 1);
  endtask

  task automatic writeOne(int hi, int lo, logic [7:0] d);
    bit a;
    int t;
    int e;
    writeHdr(hi, lo);
    sendByte(d, a); check(a, "R4 data ack", a, 1);
    busStop();
    pollReady(t);
    check(t >= 2 && t <= 4, "R6 poll count after write", t, 3);
    e = effAddr(hi, lo);
    model[e] = d;
    if (!known[e] && wlCnt < 16) begin wl[wlCnt] = e; wlCnt++; end
    known[e] = 1'b1;
    modelAddr = (e + 1) % DEPTH;
  endtask

  task automatic readSeq(bit setAddr, int hi, int lo, int n, string tag);
    bit a;
    logic [7:0] b;
    if (setAddr) begin
      writeHdr(hi, lo);
      modelAddr = effAddr(hi, lo);
    end
    busStart();
    sendByte({DEV, 1'b1}, a); check(a, "R2 read address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k < n - 1, b);
      if (known[modelAddr])
        check(b == model[modelAddr], tag, b, model[modelAddr]);
      modelAddr = (modelAddr + 1) % DEPTH;
    end
    check(sdaOe == 1'b0, "R9 released after host NACK", sdaOe, 0);
    recvByte(1'b0, b);
    check(b == 8'hFF, "R9 no drive after NACK", b, 8'hFF);
    busStop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit a;
    int t;
    int ad;
    int hi;
    logic [7:0] b;
    void'($urandom(32'h5eed));
    for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;
    hold(5);
    rstN = 1'b1;
    hold(5);
    check(sdaOe == 1'b0, "R1 reset release", sdaOe, 0);

    // R2 foreign address, then a further byte is ignored
    busStart();
    sendByte({DEV ^ 7'h01, 1'b0}, a); check(!a, "R2 foreign address NACK", a, 0);
    sendByte(8'h00, a);               check(!a, "R2 ignored after mismatch", a, 0);
    busStop();

    // directed wrap addresses with junk in the unused high bits (R3)
    writeOne(8'hF1, 8'hFE, 8'hA5);
    writeOne(8'h7D, 8'hFF, 8'h3C);
    writeOne(8'hFE, 8'h00, 8'h81);
    writeOne(8'h02, 8'h01, 8'h7E);

    // R6 read direction is also refused while busy
    writeHdr(0, 8'h40);
    sendByte(8'h11, a);
    busStop();
    model[64] = 8'h11; known[64] = 1'b1; wl[wlCnt] = 64; wlCnt++;
    busStart();
    sendByte({DEV, 1'b1}, a); check(!a, "R6 read NACK while busy", a, 0);
    busStop();
    pollReady(t);
    check(t <= 4, "R6 ready after write cycle", t, 2);

    // random writes
    for (int i = 0; i < 7; i++) begin
      ad = $urandom % DEPTH;
      hi = (ad >> 8) | (($urandom % 128) << 1);
      writeOne(hi, ad & 8'hFF, 8'($urandom));
    end

    // R4 two data bytes: the last one is stored
    writeHdr(0, 8'h80);
    sendByte(8'h12, a);
    sendByte(8'h34, a); check(a, "R4 second data ack", a, 1);
    busStop();
    pollReady(t);
    model[128] = 8'h34;
    if (!known[128]) begin known[128] = 1'b1; wl[wlCnt] = 128; wlCnt++; end
    readSeq(1, 0, 8'h80, 1, "R4 last byte stored");

    // R5 stop in the middle of a data byte
    writeHdr(0, 8'h80);
    putBits(8'h5A, 4);
    busStop();
    pollReady(t);
    check(t == 1, "R5 no write cycle after mid-byte stop", t, 1);
    // R5 stop right after the word address
    writeHdr(0, 8'h80);
    busStop();
    pollReady(t);
    check(t == 1, "R5 no write cycle after address-only stop", t, 1);
    readSeq(1, 0, 8'h80, 1, "R5 array unchanged");

    // R8 random reads of every written word
    for (int i = 0; i < wlCnt; i++)
      readSeq(1, (wl[i] >> 8) | 8'hA0, wl[i] & 8'hFF, 1, "R8 random read data");

    // R7 current address continues after a random read, then wraps
    readSeq(1, 1, 8'hFE, 1, "R8 random read at top");
    readSeq(0, 0, 0, 1, "R7 current address read");
    check(modelAddr == 0, "R7 counter wrapped", modelAddr, 0);
    readSeq(0, 0, 0, 2, "R7 current read after wrap");

    // R9 sequential read across the wrap
    readSeq(1, 1, 8'hFE, 4, "R9 sequential read data");

    check(sclHighFlips == 0, "R10 drive stable while SCL high", sclHighFlips, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule